// File: doc/BRIEF.md
# DRAM Strobe Timing Sequencer

This block turns a single-cycle local memory request into RAS and CAS strobe timing on the processor clock. It keeps track of which DRAM banks currently hold an open page and which row each page holds. It then chooses one of three paths: a page hit that goes straight to CAS, a closed bank that opens RAS first, or a conflict that releases RAS and waits out a precharge gap. A one-cycle `done` pulse marks the last clock of the CAS pulse.

A five-bit mode input controls the options. It can stretch the CAS pulse by one T-state on every access or on reads only. It can disable the idle timeout that closes an open page. It can allow more than one bank to stay open at once. It can change the RAS pins from one line per bank into an encoded bank number plus a shared timing strobe, so that an external 3-to-8 decoder can reach eight banks.

Top module: `dram_strobe_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, all `ras_n` lines are 1, `cas_n` is 1 and `done` is 0.
- R2: A request to a bank with no open page, with one-hot mode selected (mode bit 1 = 0) and no conflict, drives that bank's line `ras_n[bank]` low in the first cycle after the request edge. `cas_n` is low in cycles 2 and 3, and `done` is 1 in cycle 3 only.
- R3: A request to an open bank whose stored row equals `req_row` is a page hit. `cas_n` is low in cycles 1 and 2, and `done` is 1 in cycle 2.
- R4: A request to an open bank holding a different row releases that bank's RAS in cycle 1 and keeps it high through cycle 2 as the precharge gap. It drives RAS low again in cycle 3, drives `cas_n` low from cycle 4, and raises `done` in cycle 5 (base CAS width).
- R5: With mode bit 4 = 1, the CAS pulse lasts four clocks instead of two for both reads and writes, and `done` moves to the last of those clocks.
- R6: With mode bit 4 = 0 and mode bit 2 = 1, reads (`req_write` = 0) get the four-clock CAS pulse and writes keep the two-clock pulse.
- R7: With mode bit 0 = 0 (single-open mode), a request to a bank other than the open one closes all open RAS lines in cycle 1 and follows the R4 timing.
- R8: With mode bit 0 = 1 in one-hot mode, opening a new bank leaves other banks' RAS lines low, and the new bank follows the R2 timing.
- R9: With mode bit 3 = 0, an open bank whose access has ended closes its RAS after TIMEOUT (default 64) consecutive clocks without an access. With the default settings, after a closed-bank access whose `done` falls in cycle 3, RAS is still low in cycle 67 and high in cycle 68.
- R10: With mode bit 3 = 1, an open bank keeps RAS low however long it is left idle.
- R11: With mode bit 1 = 1 (encoded mode), `ras_n[2:0]` carries the bank number and `ras_n[3]` is an active-low strobe that is low while any bank is open. Only one bank is open at a time, even with mode bit 0 = 1. The bank number changes only while the strobe is high and is stable one clock before the strobe falls. A closed-bank access puts the number out in cycle 1, the strobe low in cycle 2 and CAS in cycles 3 and 4. A bank change releases the strobe in cycle 1, puts the new number out in cycle 2, drives the strobe low in cycle 3 and starts CAS in cycle 4.
- R12: In one-hot mode, `req_bank[2]` is ignored, so bank 6 drives `ras_n[2]`.
- R13: A request that arrives while an access is in progress is ignored. It produces no second `done` and opens no RAS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 5 | Mode bits: [4] CAS wait on all accesses, [3] timeout off, [2] CAS wait on reads, [1] encoded RAS, [0] multi-open |
| req_valid | input | 1 | One-cycle access request, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | RAS_LINES-1 | Bank number (low bits only in one-hot mode) |
| req_row | input | ROW_W | Row address used for page-hit detection |
| ras_n | output | RAS_LINES | RAS lines, one-hot active low or encoded bank plus strobe |
| cas_n | output | 1 | Active-low CAS |
| done | output | 1 | High in the last clock of the CAS pulse |

## Verification
The sequencer is driven with a closed bank, a page hit, a row miss on the same bank and a request to a different bank. Together these separate the three timing paths, because each path puts the first CAS clock in a different cycle: 1, 2 or 4. The same hit is repeated as a read and as a write under each wait setting, which shows whether the CAS stretch depends on direction. Sequences of requests across several banks, in single-open and multi-open modes and in one-hot and encoded forms, show which lines stay low and whether the bank number is settled before the strobe falls. Long idle gaps with the timeout enabled and disabled check exactly when the page closes.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_SETUP,
      ST_RCD,
      ST_CAS
   } seq_state_t;

   typedef struct packed {
      logic cas_wait_all;
      logic tmo_off;
      logic cas_wait_rd;
      logic ras_enc;
      logic multi_open;
   } seq_mode_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/dram_seq_page_trk.sv
module dram_seq_page_trk #(
   parameter int ROW_W   = 10,
   parameter int TIMEOUT = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_i,
   input  logic             close_i,
   input  logic             busy_i,
   input  logic             tmo_en_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             is_open_o,
   output logic [ROW_W-1:0] row_o
);
   localparam int CW = $clog2(TIMEOUT + 1);

   logic [CW-1:0] idle_cnt;
   logic          expire;

   assign expire = is_open_o && !busy_i && tmo_en_i && (idle_cnt == CW'(TIMEOUT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open_o <= 1'b0;
         row_o     <= '0;
         idle_cnt  <= '0;
      end else if (open_i) begin
         is_open_o <= 1'b1;
         row_o     <= row_i;
         idle_cnt  <= '0;
      end else if (close_i || expire) begin
         is_open_o <= 1'b0;
         idle_cnt  <= '0;
      end else if (busy_i || !is_open_o || !tmo_en_i) begin
         idle_cnt  <= '0;
      end else begin
         idle_cnt  <= idle_cnt + CW'(1);
      end
   end

   // R9
   idle_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_cnt < CW'(TIMEOUT));

   // R10
   tmo_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(is_open_o) && !$past(tmo_en_i)) |-> $past(close_i));

   // R9
   busy_keeps_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && is_open_o && !close_i) |=> is_open_o);

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
   import dram_seq_pkg::*;
#(
   parameter int NB       = 8,
   parameter int BW       = 3,
   parameter int OH_BW    = 2,
   parameter int ROW_W    = 10,
   parameter int TCLK     = 2,
   parameter int RCD_CLKS = 1,
   parameter int PRE_CLKS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_mode_t        mode,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [BW-1:0]    req_bank,
   input  logic [ROW_W-1:0] req_row,
   input  logic [NB-1:0]    open_vec,
   input  logic [NB-1:0]    hit_vec,
   output logic [NB-1:0]    open_pulse,
   output logic [NB-1:0]    close_mask,
   output logic [NB-1:0]    busy_vec,
   output logic [ROW_W-1:0] open_row,
   output logic [BW-1:0]    enc_bank,
   output logic             cas_act,
   output logic             done
);
   localparam int LONG_CAS = 2 * TCLK;
   localparam int MAXC     = max3(LONG_CAS, PRE_CLKS, RCD_CLKS);
   localparam int CNT_W    = $clog2(MAXC + 1);

   seq_state_t       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cur_len;
   logic [BW-1:0]    cur_bank;
   logic [ROW_W-1:0] cur_row;

   logic [BW-1:0]    eb;
   logic [NB-1:0]    eb_oh, cur_oh;
   logic [CNT_W-1:0] want_len;
   logic             accept, single, others, conflict, hit, direct_open;

   always_comb begin
      eb = mode.ras_enc ? req_bank : BW'(req_bank[OH_BW-1:0]);
   end

   assign eb_oh    = NB'(1) << eb;
   assign cur_oh   = NB'(1) << cur_bank;
   assign want_len = (mode.cas_wait_all || (mode.cas_wait_rd && !req_write))
                     ? CNT_W'(LONG_CAS) : CNT_W'(TCLK);
   assign accept   = (state == ST_IDLE) && req_valid;
   assign single   = !mode.multi_open || mode.ras_enc;
   assign others   = |(open_vec & ~eb_oh);
   assign hit      = hit_vec[eb];
   assign conflict = (open_vec[eb] && !hit) || (single && others);
   assign direct_open = accept && !conflict && !hit && !mode.ras_enc;

   always_comb begin
      open_pulse = '0;
      if (direct_open)
         open_pulse = eb_oh;
      else if ((state == ST_PRE && cnt == '0) || state == ST_SETUP)
         open_pulse = cur_oh;
   end

   always_comb begin
      close_mask = '0;
      if (accept && conflict)
         close_mask = single ? open_vec : eb_oh;
   end

   always_comb begin
      busy_vec = '0;
      if (state != ST_IDLE) busy_vec = busy_vec | cur_oh;
      if (accept)           busy_vec = busy_vec | eb_oh;
   end

   assign open_row = accept ? req_row : cur_row;
   assign cas_act  = (state == ST_CAS);
   assign done     = (state == ST_CAS) && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         cur_len  <= CNT_W'(TCLK);
         cur_bank <= '0;
         cur_row  <= '0;
         enc_bank <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  cur_bank <= eb;
                  cur_row  <= req_row;
                  cur_len  <= want_len;
                  if (conflict) begin
                     state <= ST_PRE;
                     cnt   <= CNT_W'(PRE_CLKS - 1);
                  end else if (hit) begin
                     state <= ST_CAS;
                     cnt   <= want_len - CNT_W'(1);
                  end else if (mode.ras_enc) begin
                     state    <= ST_SETUP;
                     enc_bank <= eb;
                     cnt      <= '0;
                  end else begin
                     state <= ST_RCD;
                     cnt   <= CNT_W'(RCD_CLKS - 1);
                  end
               end
            end
            ST_PRE: begin
               if (cnt == CNT_W'(PRE_CLKS - 1))
                  enc_bank <= cur_bank;
               if (cnt == '0) begin
                  state <= ST_RCD;
                  cnt   <= CNT_W'(RCD_CLKS - 1);
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_SETUP: begin
               state <= ST_RCD;
               cnt   <= CNT_W'(RCD_CLKS - 1);
            end
            ST_RCD: begin
               if (cnt == '0) begin
                  state <= ST_CAS;
                  cnt   <= cur_len - CNT_W'(1);
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_CAS: begin
               if (cnt == '0) state <= ST_IDLE;
               else           cnt   <= cnt - CNT_W'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2
   cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cas_act |-> open_vec[cur_bank]);

   // R4
   pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PRE) |-> !open_vec[cur_bank]);

   // R13
   hold_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> (cur_bank == $past(cur_bank)));

   // R5
   done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (state == ST_IDLE));

endmodule

// File: rtl/dram_seq_ras_out.sv
module dram_seq_ras_out #(
   parameter int RAS_LINES = 4,
   parameter int NB        = 8,
   parameter int BW        = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enc_mode,
   input  logic [NB-1:0]        open_vec,
   input  logic [BW-1:0]        enc_bank,
   output logic [RAS_LINES-1:0] ras_n
);
   logic strobe_n;

   assign strobe_n = ~|open_vec;

   for (genvar i = 0; i < RAS_LINES; i++) begin : g_line
      if (i < RAS_LINES - 1) begin : g_addr
         assign ras_n[i] = enc_mode ? enc_bank[i] : ~open_vec[i];
      end else begin : g_strobe
         assign ras_n[i] = enc_mode ? strobe_n : ~open_vec[i];
      end
   end

   // R11
   enc_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_mode && $fell(strobe_n)) |-> $stable(enc_bank));

   // R11
   enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_mode && $past(enc_mode) && !$past(strobe_n)) |-> $stable(enc_bank));

   // R11
   enc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_mode |-> $onehot0(open_vec));

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
   import dram_seq_pkg::*;
#(
   parameter int RAS_LINES   = 4,
   parameter int ROW_W       = 10,
   parameter int TIMEOUT     = 64,
   parameter int TSTATE_CLKS = 2,
   parameter int RCD_CLKS    = 1,
   parameter int PRE_CLKS    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [4:0]           cfg_mode,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [RAS_LINES-2:0] req_bank,
   input  logic [ROW_W-1:0]     req_row,
   output logic [RAS_LINES-1:0] ras_n,
   output logic                 cas_n,
   output logic                 done
);
   localparam int BW    = RAS_LINES - 1;
   localparam int NB    = 2 ** BW;
   localparam int OH_BW = $clog2(RAS_LINES);

   if (RAS_LINES < 2 || RAS_LINES > 8 || (2 ** OH_BW) != RAS_LINES) begin : g_bad_lines
      $error("RAS_LINES must be a power of two from 2 to 8");
   end
   if (TIMEOUT < 16) begin : g_bad_tmo
      $error("TIMEOUT must exceed the longest access");
   end
   if (PRE_CLKS < 2 || RCD_CLKS < 1 || TSTATE_CLKS < 1) begin : g_bad_timing
      $error("timing counts out of range");
   end

   seq_mode_t        mode;
   logic [NB-1:0]    open_vec, hit_vec, open_pulse, close_mask, busy_vec;
   logic [ROW_W-1:0] open_row;
   logic [BW-1:0]    enc_bank;
   logic             cas_act;

   assign mode = seq_mode_t'(cfg_mode);

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [ROW_W-1:0] row_q;
      dram_seq_page_trk #(
         .ROW_W   (ROW_W),
         .TIMEOUT (TIMEOUT)
      ) u_trk (
         .clk       (clk),
         .rst_n     (rst_n),
         .open_i    (open_pulse[b]),
         .close_i   (close_mask[b]),
         .busy_i    (busy_vec[b]),
         .tmo_en_i  (!mode.tmo_off),
         .row_i     (open_row),
         .is_open_o (open_vec[b]),
         .row_o     (row_q)
      );
      assign hit_vec[b] = open_vec[b] && (row_q == req_row);
   end

   dram_seq_ctrl #(
      .NB       (NB),
      .BW       (BW),
      .OH_BW    (OH_BW),
      .ROW_W    (ROW_W),
      .TCLK     (TSTATE_CLKS),
      .RCD_CLKS (RCD_CLKS),
      .PRE_CLKS (PRE_CLKS)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_bank   (req_bank),
      .req_row    (req_row),
      .open_vec   (open_vec),
      .hit_vec    (hit_vec),
      .open_pulse (open_pulse),
      .close_mask (close_mask),
      .busy_vec   (busy_vec),
      .open_row   (open_row),
      .enc_bank   (enc_bank),
      .cas_act    (cas_act),
      .done       (done)
   );

   dram_seq_ras_out #(
      .RAS_LINES (RAS_LINES),
      .NB        (NB),
      .BW        (BW)
   ) u_ras (
      .clk      (clk),
      .rst_n    (rst_n),
      .enc_mode (mode.ras_enc),
      .open_vec (open_vec),
      .enc_bank (enc_bank),
      .ras_n    (ras_n)
   );

   assign cas_n = ~cas_act;

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (cas_n && !done));

endmodule

// File: tb/dram_strobe_seq_bench.sv
`timescale 1ns/1ps
module dram_strobe_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] cfg_mode = '0;
   logic       req_valid = 1'b0;
   logic       req_write = 1'b0;
   logic [2:0] req_bank = '0;
   logic [9:0] req_row = '0;
   logic [3:0] ras_n;
   logic       cas_n;
   logic       done;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [3:0] tr_ras [1:12];
   logic       tr_cas [1:12];
   logic       tr_done[1:12];

   always #2 clk = ~clk;

   dram_strobe_seq u_dram_strobe_seq (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
      .req_valid(req_valid), .req_write(req_write),
      .req_bank(req_bank), .req_row(req_row),
      .ras_n(ras_n), .cas_n(cas_n), .done(done)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int cas_first();
      for (int i = 1; i <= 12; i++) if (!tr_cas[i]) return i;
      return 0;
   endfunction
   function automatic int cas_count();
      int n = 0;
      for (int i = 1; i <= 12; i++) if (!tr_cas[i]) n++;
      return n;
   endfunction
   function automatic int done_first();
      for (int i = 1; i <= 12; i++) if (tr_done[i]) return i;
      return 0;
   endfunction
   function automatic int done_count();
      int n = 0;
      for (int i = 1; i <= 12; i++) if (tr_done[i]) n++;
      return n;
   endfunction

   // one-cycle request, then 12 cycles recorded; optional stray request while busy
   task automatic access(input bit w, input int b, input int row, input int stray_b);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_bank = 3'(b); req_row = 10'(row);
      for (int i = 1; i <= 12; i++) begin
         @(negedge clk);
         if (i == 1) begin
            req_valid = 1'b0;
            if (stray_b >= 0) begin
               req_valid = 1'b1; req_bank = 3'(stray_b); req_row = 10'd7;
            end
         end
         if (i == 2) req_valid = 1'b0;
         tr_ras[i] = ras_n; tr_cas[i] = cas_n; tr_done[i] = done;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req_valid = 1'b0; cfg_mode = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      check("R1 ras", ras_n, 4'hF);
      check("R1 cas", cas_n, 1);
      check("R1 done", done, 0);
   endtask

   task automatic t_paths();
      cfg_mode = 5'h00;
      access(0, 1, 5, -1);
      check("R2 ras cycle1", tr_ras[1], 4'b1101);
      check("R2 cas first", cas_first(), 2);
      check("R2 cas width", cas_count(), 2);
      check("R2 done", done_first(), 3);
      access(1, 1, 5, -1);
      check("R3 cas first", cas_first(), 1);
      check("R3 done", done_first(), 2);
      access(0, 1, 9, -1);
      check("R4 released", tr_ras[1], 4'hF);
      check("R4 gap", tr_ras[2], 4'hF);
      check("R4 reopen", tr_ras[3], 4'b1101);
      check("R4 cas first", cas_first(), 4);
      check("R4 done", done_first(), 5);
   endtask

   task automatic t_waits();
      cfg_mode = 5'h10;
      access(1, 1, 9, -1);
      check("R5 write width", cas_count(), 4);
      check("R5 write done", done_first(), 4);
      access(0, 1, 9, -1);
      check("R5 read width", cas_count(), 4);
      cfg_mode = 5'h04;
      access(0, 1, 9, -1);
      check("R6 read width", cas_count(), 4);
      access(1, 1, 9, -1);
      check("R6 write width", cas_count(), 2);
      check("R6 write done", done_first(), 2);
   endtask

   task automatic t_banks();
      cfg_mode = 5'h00;
      access(0, 2, 1, -1);
      check("R7 all closed", tr_ras[1], 4'hF);
      check("R7 new bank", tr_ras[3], 4'b1011);
      check("R7 done", done_first(), 5);
      cfg_mode = 5'h01;
      access(0, 0, 3, -1);
      check("R8 both open", tr_ras[1], 4'b1010);
      check("R8 done", done_first(), 3);
      access(0, 3, 0, 1);
      check("R13 single done", done_count(), 1);
      check("R13 stray no ras", tr_ras[12], 4'b0010);
   endtask

   task automatic t_timeout();
      logic a, b;
      do_reset();
      access(0, 0, 4, -1);
      check("R9 done", done_first(), 3);
      for (int k = 13; k <= 68; k++) begin
         @(negedge clk);
         if (k == 67) a = ras_n[0];
         if (k == 68) b = ras_n[0];
      end
      check("R9 still open", a, 0);
      check("R9 closed", b, 1);
      do_reset();
      cfg_mode = 5'h08;
      access(0, 0, 4, -1);
      for (int k = 13; k <= 90; k++) @(negedge clk);
      check("R10 held open", ras_n[0], 0);
   endtask

   task automatic t_encoded();
      do_reset();
      cfg_mode = 5'h02;
      access(0, 5, 2, -1);
      check("R11 number first", tr_ras[1], 4'b1101);
      check("R11 strobe low", tr_ras[2], 4'b0101);
      check("R11 cas first", cas_first(), 3);
      check("R11 done", done_first(), 4);
      cfg_mode = 5'h03;
      access(0, 3, 2, -1);
      check("R11 strobe up", tr_ras[1], 4'b1101);
      check("R11 new number", tr_ras[2], 4'b1011);
      check("R11 strobe down", tr_ras[3], 4'b0011);
      check("R11 switch cas", cas_first(), 4);
   endtask

   task automatic t_bit2();
      do_reset();
      access(0, 6, 0, -1);
      check("R12 bank6 to line2", tr_ras[1], 4'b1011);
      check("R12 done", done_first(), 3);
   endtask

   initial begin
      t_reset();
      t_paths();
      t_waits();
      t_banks();
      t_timeout();
      t_encoded();
      t_bit2();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule